// File: doc/BRIEF.md
# RTC Register Interface

This block is the software-facing register file of a real-time clock. It sits on an APB4 bus and gives the clock core its run controls, its prescaler and alarm values, and one-cycle load pulses for the prescaler, counter and alarm. It also collects the core's second, alarm and overflow events into interrupt flags and shows two status inputs to software. Six 32-bit word registers are decoded: control at 0x0, prescaler at 0x4, counter at 0x8, alarm at 0xC, interrupt flags at 0x10 and system status at 0x14. Every transfer is a whole-word access. The two low address bits are not decoded.

The prescaler and counter are protected. A write to either one is accepted only while the configuration flag in the control register is already set. Software therefore sets the flag, loads the values, clears the flag and then enables counting. The interrupt flags are cleared by writing 0 to a flag bit. Writing 1 to a flag bit leaves that flag unchanged. Clock-domain crossing to the slow counting clock is done by a separate synchronizer. The counter itself lives in the core, and its value comes back to this block on `cntIn`.

Top module: `rtc_apb_regs`

## Requirements
- R1: After reset, control reads 0x0, prescaler reads 0x2, alarm reads 0x0 and the interrupt flags read 0x0. All control outputs and load pulses are low.
- R2: Control bits are bit 4 = count enable, bit 3 = overflow interrupt enable, bit 2 = alarm interrupt enable, bit 1 = second interrupt enable and bit 0 = configuration flag. The bits can be written at any time and read back. Bits [31:5] read 0, and each control bit drives its own output.
- R3: A prescaler write made while the configuration flag was set stores data bits [19:0] in `pscVal`. It also raises `pscLoad` for the one cycle after the access edge. Bits [31:20] read 0.
- R4: A counter write made while the configuration flag was set raises `cntLoad` for the one cycle after the access edge, with `cntLoadVal` equal to the written word. Reads at 0x8 return `cntIn`.
- R5: A prescaler or counter write made while the configuration flag is clear is dropped. No load pulse is produced and the prescaler keeps its value.
- R6: An alarm write is accepted at any time. It updates `alrmVal` and raises `alrmLoad` for one cycle, and the value reads back at 0xC.
- R7: An event pulse sets its flag on the next edge. The flags are bit 2 = overflow, bit 1 = alarm and bit 0 = second, they appear on `intFlags` and at 0x10, and bits [31:3] read 0.
- R8: A write to 0x10 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R9: When an event and a clearing write to its flag arrive in the same cycle, the flag ends set.
- R10: 0x14 reads `lastWrDone` on bit 1 and `regsSynced` on bit 0, with all other bits 0. Writes to it change nothing.
- R11: Every access completes with `pready` high and `pslverr` low. Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | Write transfer |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the read access phase, 0 otherwise |
| pready | output | 1 | Transfer done (always high) |
| pslverr | output | 1 | Error response (always low) |
| cntIn | input | CNT_W | Live counter value from the core |
| evtSec | input | 1 | Second event pulse |
| evtAlrm | input | 1 | Alarm match pulse |
| evtOvf | input | 1 | Counter overflow pulse |
| lastWrDone | input | 1 | Last write has finished in the core |
| regsSynced | input | 1 | Registers synchronized flag |
| cntEnable | output | 1 | Count enable |
| ovfIntEn | output | 1 | Overflow interrupt enable |
| alrmIntEn | output | 1 | Alarm interrupt enable |
| secIntEn | output | 1 | Second interrupt enable |
| cfgMode | output | 1 | Configuration flag |
| pscVal | output | PSC_W | Prescaler value |
| pscLoad | output | 1 | Prescaler load pulse |
| cntLoad | output | 1 | Counter load pulse |
| cntLoadVal | output | CNT_W | Value to load into the counter |
| alrmVal | output | CNT_W | Alarm value |
| alrmLoad | output | 1 | Alarm load pulse |
| intFlags | output | 3 | Interrupt flags {overflow, alarm, second} |

## Verification
The bench builds the block with ADDR_W = 8 and keeps the default 20-bit prescaler and 32-bit counter. With ADDR_W = 8, unmapped offsets up to 0xFC can be reached, so it can check that writes past the six registers land nowhere and that those reads return 0. The full-width counter and prescaler let the bench write patterns with bits set above the prescaler field, so truncation and the zero reserved bits are visible. The same settings also make the same-cycle collision between an event and a flag clear reachable.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_PSC  = 3'd1,
    SEL_CNT  = 3'd2,
    SEL_ALRM = 3'd3,
    SEL_ISTA = 3'd4,
    SEL_SSTA = 3'd5,
    SEL_NONE = 3'd7
  } regSel_e;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    logic    wrCtrl;
    logic    wrPsc;
    logic    wrCnt;
    logic    wrAlrm;
    logic    wrIsta;
    logic    rdEn;
    regSel_e rdSel;
  } regStrobe_t;

  localparam int unsigned CTRL_W    = 5;
  localparam int unsigned CTL_CFG   = 0;
  localparam int unsigned CTL_SECIE = 1;
  localparam int unsigned CTL_ALRIE = 2;
  localparam int unsigned CTL_OVFIE = 3;
  localparam int unsigned CTL_EN    = 4;

  localparam int unsigned FLG_N    = 3;
  localparam int unsigned FLG_SEC  = 0;
  localparam int unsigned FLG_ALRM = 1;
  localparam int unsigned FLG_OVF  = 2;

endpackage

// File: rtl/rtc_reg_ctrl.sv
module rtc_reg_ctrl
  import rtc_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              cfgMode,
  output regStrobe_t        stb
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             unusedAddrLow;
  regSel_e          sel;
  logic             access;
  logic             wrAcc;

  assign wordIdx       = paddr[ADDR_W-1:2];
  assign unusedAddrLow = ^paddr[1:0];
  assign access        = psel & penable;
  assign wrAcc         = access & pwrite;

  always_comb begin
    sel = SEL_NONE;
    if (wordIdx == IDX_W'(0)) sel = SEL_CTRL;
    else if (wordIdx == IDX_W'(1)) sel = SEL_PSC;
    else if (wordIdx == IDX_W'(2)) sel = SEL_CNT;
    else if (wordIdx == IDX_W'(3)) sel = SEL_ALRM;
    else if (wordIdx == IDX_W'(4)) sel = SEL_ISTA;
    else if (wordIdx == IDX_W'(5)) sel = SEL_SSTA;
  end

  always_comb begin
    stb.wrCtrl = wrAcc & (sel == SEL_CTRL);
    stb.wrPsc  = wrAcc & (sel == SEL_PSC) & cfgMode;
    stb.wrCnt  = wrAcc & (sel == SEL_CNT) & cfgMode;
    stb.wrAlrm = wrAcc & (sel == SEL_ALRM);
    stb.wrIsta = wrAcc & (sel == SEL_ISTA);
    stb.rdEn   = access & ~pwrite;
    stb.rdSel  = sel;
  end

endmodule

// File: rtl/rtc_int_flags.sv
module rtc_int_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] evt,
  input  logic         wrEn,
  input  logic [N-1:0] wrBits,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic clrHit;
    assign clrHit = wrEn & ~wrBits[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flags[i] <= 1'b0;
      else       flags[i] <= evt[i] | (flags[i] & ~clrHit);
    end

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      evt[i] |=> flags[i]);
    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (flags[i] && !(wrEn && !wrBits[i])) |=> flags[i]);
    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && !wrBits[i] && !evt[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/rtc_reg_data.sv
module rtc_reg_data
  import rtc_regs_pkg::*;
#(
  parameter int unsigned         PSC_W   = 20,
  parameter int unsigned         CNT_W   = 32,
  parameter int unsigned         DATA_W  = 32,
  parameter logic [PSC_W-1:0]    PSC_RST = PSC_W'(2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         stb,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [CNT_W-1:0]   cntIn,
  input  logic [FLG_N-1:0]   evt,
  input  logic               lastWrDone,
  input  logic               regsSynced,
  output logic [CTRL_W-1:0]  ctrlReg,
  output logic [PSC_W-1:0]   pscVal,
  output logic               pscLoad,
  output logic               cntLoad,
  output logic [CNT_W-1:0]   cntLoadVal,
  output logic [CNT_W-1:0]   alrmVal,
  output logic               alrmLoad,
  output logic [FLG_N-1:0]   intFlags,
  output logic [DATA_W-1:0]  rdata
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      pscVal     <= PSC_RST;
      pscLoad    <= 1'b0;
      cntLoad    <= 1'b0;
      cntLoadVal <= '0;
      alrmVal    <= '0;
      alrmLoad   <= 1'b0;
    end else begin
      pscLoad  <= stb.wrPsc;
      cntLoad  <= stb.wrCnt;
      alrmLoad <= stb.wrAlrm;
      if (stb.wrCtrl) ctrlReg    <= wdata[CTRL_W-1:0];
      if (stb.wrPsc)  pscVal     <= wdata[PSC_W-1:0];
      if (stb.wrCnt)  cntLoadVal <= wdata[CNT_W-1:0];
      if (stb.wrAlrm) alrmVal    <= wdata[CNT_W-1:0];
    end
  end

  rtc_int_flags #(.N(FLG_N)) u_flags (
    .clk    (clk),
    .rstN   (rstN),
    .evt    (evt),
    .wrEn   (stb.wrIsta),
    .wrBits (wdata[FLG_N-1:0]),
    .flags  (intFlags)
  );

  always_comb begin
    rdata = '0;
    if (stb.rdEn) begin
      case (stb.rdSel)
        SEL_CTRL: rdata = DATA_W'(ctrlReg);
        SEL_PSC:  rdata = DATA_W'(pscVal);
        SEL_CNT:  rdata = DATA_W'(cntIn);
        SEL_ALRM: rdata = DATA_W'(alrmVal);
        SEL_ISTA: rdata = DATA_W'(intFlags);
        SEL_SSTA: rdata = DATA_W'({lastWrDone, regsSynced});
        default:  rdata = '0;
      endcase
    end
  end

  // R5
  psc_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    pscLoad |-> $past(ctrlReg[CTL_CFG]));
  // R5
  cnt_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntLoad |-> $past(ctrlReg[CTL_CFG]));
  // R3
  psc_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pscVal) |-> pscLoad);
  // R6
  alrm_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(alrmVal) |-> alrmLoad);

endmodule

// File: rtl/rtc_apb_regs.sv
module rtc_apb_regs
  import rtc_regs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned PSC_W   = 20,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned PSC_RST = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic              evtSec,
  input  logic              evtAlrm,
  input  logic              evtOvf,
  input  logic              lastWrDone,
  input  logic              regsSynced,
  output logic              cntEnable,
  output logic              ovfIntEn,
  output logic              alrmIntEn,
  output logic              secIntEn,
  output logic              cfgMode,
  output logic [PSC_W-1:0]  pscVal,
  output logic              pscLoad,
  output logic              cntLoad,
  output logic [CNT_W-1:0]  cntLoadVal,
  output logic [CNT_W-1:0]  alrmVal,
  output logic              alrmLoad,
  output logic [2:0]        intFlags
);
  localparam int unsigned DATA_W = 32;

  regStrobe_t          stb;
  logic [CTRL_W-1:0]   ctrlReg;
  logic [FLG_N-1:0]    evtVec;

  always_comb begin
    evtVec           = '0;
    evtVec[FLG_SEC]  = evtSec;
    evtVec[FLG_ALRM] = evtAlrm;
    evtVec[FLG_OVF]  = evtOvf;
  end

  rtc_reg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .cfgMode (ctrlReg[CTL_CFG]),
    .stb     (stb)
  );

  rtc_reg_data #(
    .PSC_W   (PSC_W),
    .CNT_W   (CNT_W),
    .DATA_W  (DATA_W),
    .PSC_RST (PSC_W'(PSC_RST))
  ) u_data (
    .clk        (pclk),
    .rstN       (presetn),
    .stb        (stb),
    .wdata      (pwdata),
    .cntIn      (cntIn),
    .evt        (evtVec),
    .lastWrDone (lastWrDone),
    .regsSynced (regsSynced),
    .ctrlReg    (ctrlReg),
    .pscVal     (pscVal),
    .pscLoad    (pscLoad),
    .cntLoad    (cntLoad),
    .cntLoadVal (cntLoadVal),
    .alrmVal    (alrmVal),
    .alrmLoad   (alrmLoad),
    .intFlags   (intFlags),
    .rdata      (prdata)
  );

  assign cntEnable = ctrlReg[CTL_EN];
  assign ovfIntEn  = ctrlReg[CTL_OVFIE];
  assign alrmIntEn = ctrlReg[CTL_ALRIE];
  assign secIntEn  = ctrlReg[CTL_SECIE];
  assign cfgMode   = ctrlReg[CTL_CFG];
  assign pready    = 1'b1;
  assign pslverr   = 1'b0;

endmodule

// File: tb/tb_rtc_apb_regs.sv
module tb_rtc_apb_regs;
  localparam int unsigned ADDR_W = 8;

  typedef struct {
    string       tag;
    logic [31:0] val;
  } item_t;

  logic clk = 1'b0;
  logic presetn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic [31:0] cntIn = '0;
  logic evtSec = 1'b0, evtAlrm = 1'b0, evtOvf = 1'b0;
  logic lastWrDone = 1'b0, regsSynced = 1'b0;
  logic cntEnable, ovfIntEn, alrmIntEn, secIntEn, cfgMode;
  logic [19:0] pscVal;
  logic pscLoad, cntLoad, alrmLoad;
  logic [31:0] cntLoadVal, alrmVal;
  logic [2:0] intFlags;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  item_t expQ[$];
  item_t actQ[$];

  always #10 clk = ~clk;

  rtc_apb_regs #(.ADDR_W(ADDR_W)) dut (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .cntIn(cntIn), .evtSec(evtSec),
    .evtAlrm(evtAlrm), .evtOvf(evtOvf), .lastWrDone(lastWrDone),
    .regsSynced(regsSynced), .cntEnable(cntEnable), .ovfIntEn(ovfIntEn),
    .alrmIntEn(alrmIntEn), .secIntEn(secIntEn), .cfgMode(cfgMode),
    .pscVal(pscVal), .pscLoad(pscLoad), .cntLoad(cntLoad),
    .cntLoadVal(cntLoadVal), .alrmVal(alrmVal), .alrmLoad(alrmLoad),
    .intFlags(intFlags)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: pops captured read data and compares against the expected queue.
  always @(negedge clk) begin
    while (actQ.size() > 0 && expQ.size() > 0) begin
      item_t a;
      item_t e;
      a = actQ.pop_front();
      e = expQ.pop_front();
      chk(e.tag, a.val, e.val);
    end
  end

  // Called at a negedge; returns at the negedge after the access edge.
  task automatic apbWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                          input logic [2:0] evt);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    {evtOvf, evtAlrm, evtSec} = evt;
    #2;
    chk("R11 write ready/err", {30'd0, pready, pslverr}, 32'h2);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    {evtOvf, evtAlrm, evtSec} = 3'b000;
  endtask

  task automatic apbRead(input logic [ADDR_W-1:0] a, input logic [31:0] exp,
                         input string tag);
    item_t e;
    item_t r;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #2;
    chk("R11 read ready/err", {30'd0, pready, pslverr}, 32'h2);
    e.tag = tag; e.val = exp;
    r.tag = tag; r.val = prdata;
    expQ.push_back(e);
    actQ.push_back(r);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic pulseEvt(input logic [2:0] evt);
    {evtOvf, evtAlrm, evtSec} = evt;
    @(negedge clk);
    {evtOvf, evtAlrm, evtSec} = 3'b000;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    presetn = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 outputs", {21'd0, cntEnable, ovfIntEn, alrmIntEn, secIntEn, cfgMode,
                       pscLoad, cntLoad, alrmLoad, intFlags}, 32'h0);
    apbRead(8'h00, 32'h0, "R1 ctrl reset");
    apbRead(8'h04, 32'h2, "R1 psc reset");
    apbRead(8'h0C, 32'h0, "R1 alarm reset");
    apbRead(8'h10, 32'h0, "R1 flags reset");

    // R2 control bits
    apbWrite(8'h00, 32'hFFFF_FFFF, 3'b000);
    apbRead(8'h00, 32'h1F, "R2 ctrl all ones");
    chk("R2 ctrl outputs", {27'd0, cntEnable, ovfIntEn, alrmIntEn, secIntEn, cfgMode}, 32'h1F);
    apbWrite(8'h00, 32'h0000_0014, 3'b000);
    chk("R2 ctrl pattern", {27'd0, cntEnable, ovfIntEn, alrmIntEn, secIntEn, cfgMode}, 32'h14);
    apbWrite(8'h00, 32'h0000_0001, 3'b000);

    // R3 prescaler in config mode
    apbWrite(8'h04, 32'hABCD_E123, 3'b000);
    chk("R3 pscLoad pulse", {31'd0, pscLoad}, 32'h1);
    chk("R3 pscVal", {12'd0, pscVal}, 32'h000D_E123);
    @(negedge clk);
    chk("R3 pscLoad one cycle", {31'd0, pscLoad}, 32'h0);
    apbRead(8'h04, 32'h000D_E123, "R3 psc readback");

    // R4 counter in config mode
    apbWrite(8'h08, 32'h1234_5678, 3'b000);
    chk("R4 cntLoad pulse", {31'd0, cntLoad}, 32'h1);
    chk("R4 cntLoadVal", cntLoadVal, 32'h1234_5678);
    @(negedge clk);
    chk("R4 cntLoad one cycle", {31'd0, cntLoad}, 32'h0);
    cntIn = 32'hCAFE_F00D;
    apbRead(8'h08, 32'hCAFE_F00D, "R4 cnt read");

    // R5 writes dropped outside config mode
    apbWrite(8'h00, 32'h0000_0010, 3'b000);
    apbWrite(8'h04, 32'h0000_0005, 3'b000);
    chk("R5 no pscLoad", {31'd0, pscLoad}, 32'h0);
    apbRead(8'h04, 32'h000D_E123, "R5 psc kept");
    apbWrite(8'h08, 32'h0BAD_0BAD, 3'b000);
    chk("R5 no cntLoad", {31'd0, cntLoad}, 32'h0);

    // R6 alarm
    apbWrite(8'h0C, 32'h89AB_CDEF, 3'b000);
    chk("R6 alrmLoad pulse", {31'd0, alrmLoad}, 32'h1);
    chk("R6 alrmVal", alrmVal, 32'h89AB_CDEF);
    apbRead(8'h0C, 32'h89AB_CDEF, "R6 alarm readback");

    // R7 events set flags
    pulseEvt(3'b101);
    chk("R7 intFlags ovf+sec", {29'd0, intFlags}, 32'h5);
    apbRead(8'h10, 32'h5, "R7 flags read");
    pulseEvt(3'b010);
    apbRead(8'h10, 32'h7, "R7 alarm flag");

    // R8 write 0 clears, write 1 keeps
    apbWrite(8'h10, 32'hFFFF_FFFD, 3'b000);
    apbRead(8'h10, 32'h5, "R8 clear alarm only");
    apbWrite(8'h10, 32'h0, 3'b000);
    apbRead(8'h10, 32'h0, "R8 clear all");

    // R9 event wins over clear in the same cycle
    pulseEvt(3'b001);
    apbWrite(8'h10, 32'h0, 3'b010);
    chk("R9 intFlags", {29'd0, intFlags}, 32'h2);
    apbRead(8'h10, 32'h2, "R9 flags read");

    // R10 system status
    lastWrDone = 1'b1; regsSynced = 1'b0;
    apbRead(8'h14, 32'h2, "R10 status 10");
    apbWrite(8'h14, 32'hFFFF_FFFF, 3'b000);
    apbRead(8'h14, 32'h2, "R10 status after write");
    regsSynced = 1'b1;
    apbRead(8'h14, 32'h3, "R10 status 11");

    // R11 unmapped offsets
    apbRead(8'h18, 32'h0, "R11 unmapped 0x18");
    apbRead(8'hFC, 32'h0, "R11 unmapped 0xFC");
    apbWrite(8'h20, 32'hFFFF_FFFF, 3'b000);
    apbWrite(8'h40, 32'hFFFF_FFFF, 3'b000);
    apbRead(8'h00, 32'h10, "R11 ctrl untouched");
    apbRead(8'h04, 32'h000D_E123, "R11 psc untouched");
    apbRead(8'h0C, 32'h89AB_CDEF, "R11 alarm untouched");
    apbRead(8'h10, 32'h2, "R11 flags untouched");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule